// File: doc/BRIEF.md
# Opcode Fetch Burst Sequencer

This block issues the bus accesses that bring one script instruction in from main memory. An instruction is two, three or four 32-bit Dwords long. The length depends on its type, and the type only becomes known once the first Dword has arrived. The block latches the fetch address and the burst mode when a fetch starts. It then splits the instruction into bus ownerships and passes every received Dword on, tagged with its position in the instruction.

When burst mode is on, the opening ownership always carries two beats. The rest of the instruction then follows in one further ownership:
- a memory-to-memory move or an indirect instruction adds a single beat;
- a table-indirect block move adds a second two-beat burst.

When burst mode is off, every Dword gets its own single-beat ownership. The block is meant for fetches from external memory with prefetching disabled. On-chip script RAM fetches do not go through it.

The start interface is valid/ready. A fetch is taken on a cycle where `start_valid` and `start_ready` are both high, and `start_ready` stays low until the fetch has finished. The outgoing word stream has no ready signal, because the memory bus cannot be stalled in the middle of a burst. A consumer must therefore accept one word per cycle whenever `word_valid` is high.

Top module: `ofb_seq`

## Requirements
- R1: `start_ready` is high exactly when no fetch is in progress. A fetch is accepted when `start_valid` and `start_ready` are both high, and `start_addr` and `burst_en` are latched at that edge.
- R2: The first access of a fetch requests `start_addr` with `bus_len` = 2 when the latched burst mode is 1, and with `bus_len` = 1 otherwise. `bus_len` is the beat count as an unsigned number.
- R3: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_addr` and `bus_len` hold steady. The cycle in which `bus_gnt` is seen is the last cycle of the request.
- R4: `itype` is sampled only with the beat at position 0. Its encoding sets the instruction length: 0 = plain (2 Dwords), 1 = memory-to-memory move (3), 2 = indirect (3), 3 = table-indirect block move (4). No further access is requested once that many Dwords have arrived.
- R5: With burst mode on, type 1 or 2 gets a second ownership of `bus_len` = 1 at `start_addr` + 8.
- R6: With burst mode on, type 3 gets a second ownership of `bus_len` = 2 at `start_addr` + 8.
- R7: With burst mode off, Dword i is fetched by its own access with `bus_len` = 1 at `start_addr` + 4·i.
- R8: After the final beat of an ownership (`bus_dvalid` and `bus_last`), `bus_req` is low in the next cycle. It is never raised before that beat.
- R9: Every data beat appears one cycle later on `word_valid`, with its data on `word_data` and its position (0 to 3) on `word_idx`. Positions go in ascending order.
- R10: `instr_done` is high for exactly one cycle, in the same cycle as the word of the final position.
- R11: A change of `burst_en` after a fetch has been accepted does not affect that fetch's grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Fetch request |
| start_ready | output | 1 | Idle, fetch can be accepted |
| start_addr | input | AW | Byte address of the instruction |
| burst_en | input | 1 | Burst mode, latched at start |
| bus_req | output | 1 | Bus ownership request |
| bus_addr | output | AW | Address of the first beat of the access |
| bus_len | output | 2 | Beats in the access (1 or 2) |
| bus_gnt | input | 1 | Grant, one cycle |
| bus_dvalid | input | 1 | Read data beat valid |
| bus_rdata | input | DW | Read data |
| bus_last | input | 1 | Final beat of the access |
| itype | input | 2 | Decoded instruction type, valid with beat 0 |
| word_valid | output | 1 | Word output valid |
| word_data | output | DW | Fetched Dword |
| word_idx | output | 2 | Position of the Dword in the instruction |
| instr_done | output | 1 | Final Dword of the instruction |

## Verification
A stored type or beat count that is wrong shows up at the first ownership boundary after beat 0. The block either raises an extra request or skips one, or it asks for the wrong `bus_len` or address. The bench sees this within a cycle of the gap. A sequencing error in the output stage shows in the very next cycle as a `word_idx` or `instr_done` mismatch. A stuck controller is caught as `start_ready` staying low once the last Dword has arrived.

// File: rtl/ofb_pkg.sv
package ofb_pkg;
  localparam int MAX_WORDS = 4;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_GAP
  } ofb_state_t;

  typedef enum logic [1:0] {
    IT_PLAIN    = 2'd0,
    IT_MEMMOVE  = 2'd1,
    IT_INDIRECT = 2'd2,
    IT_TABLE    = 2'd3
  } ofb_itype_t;

  function automatic logic [CNT_W-1:0] instr_words(ofb_itype_t t);
    case (t)
      IT_PLAIN:    instr_words = CNT_W'(2);
      IT_MEMMOVE:  instr_words = CNT_W'(3);
      IT_INDIRECT: instr_words = CNT_W'(3);
      default:     instr_words = CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/ofb_plan.sv
module ofb_plan
  import ofb_pkg::*;
(
  input  logic             burst,
  input  ofb_itype_t       kind,
  input  logic [CNT_W-1:0] got,
  output logic             fin_on_beat,
  output logic [1:0]       next_len
);
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] left;

  always_comb begin
    total       = instr_words(kind);
    left        = total - got;
    fin_on_beat = (got + CNT_W'(1)) == total;
    next_len    = (burst && left >= CNT_W'(2)) ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/ofb_fsm.sv
module ofb_fsm
  import ofb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [AW-1:0]    start_addr,
  input  logic             burst_en,
  output logic             bus_req,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_len,
  input  logic             bus_gnt,
  input  logic             bus_dvalid,
  input  logic             bus_last,
  input  logic [1:0]       itype,
  output logic             beat,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_final
);
  ofb_state_t       state_q;
  logic             burst_q;
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;
  ofb_itype_t       type_q;
  logic [1:0]       len_q;
  ofb_itype_t       kind_eff;
  logic             fin_on_beat;
  logic [1:0]       next_len;

  // The type arrives with beat 0 and is stored there. After that the stored copy is used.
  assign kind_eff = (cnt_q == '0) ? ofb_itype_t'(itype) : type_q;

  ofb_plan u_plan (
    .burst      (burst_q),
    .kind       (kind_eff),
    .got        (cnt_q),
    .fin_on_beat(fin_on_beat),
    .next_len   (next_len)
  );

  assign start_ready = (state_q == ST_IDLE);
  assign bus_req     = (state_q == ST_REQ);
  assign bus_addr    = base_q + AW'({cnt_q, 2'b00});
  assign bus_len     = len_q;
  assign beat        = (state_q == ST_DATA) && bus_dvalid;
  assign beat_idx    = cnt_q[IDX_W-1:0];
  assign beat_final  = beat && bus_last && fin_on_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      type_q  <= IT_PLAIN;
      len_q   <= 2'd1;
    end else begin
      case (state_q)
        ST_IDLE: if (start_valid) begin
          state_q <= ST_REQ;
          base_q  <= start_addr;
          burst_q <= burst_en;
          cnt_q   <= '0;
          len_q   <= burst_en ? 2'd2 : 2'd1;
        end
        ST_REQ: if (bus_gnt) state_q <= ST_DATA;
        ST_DATA: if (bus_dvalid) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == '0) type_q <= ofb_itype_t'(itype);
          if (bus_last) state_q <= fin_on_beat ? ST_IDLE : ST_GAP;
        end
        default: begin
          state_q <= ST_REQ;
          len_q   <= next_len;
        end
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_len)));

  assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && bus_last) |=> !bus_req);

  assert_single_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !burst_q) |-> (bus_len == 2'd1));

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
endmodule

// File: rtl/ofb_word_out.sv
module ofb_word_out
  import ofb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [DW-1:0]    beat_data,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             beat_final,
  output logic             word_valid,
  output logic [DW-1:0]    word_data,
  output logic [IDX_W-1:0] word_idx,
  output logic             instr_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
      instr_done <= 1'b0;
    end else begin
      word_valid <= beat;
      instr_done <= beat_final;
      if (beat) begin
        word_data <= beat_data;
        word_idx  <= beat_idx;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_done_with_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> word_valid);
endmodule

// File: rtl/ofb_seq.sv
module ofb_seq
  import ofb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [AW-1:0] start_addr,
  input  logic          burst_en,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_len,
  input  logic          bus_gnt,
  input  logic          bus_dvalid,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_last,
  input  logic [1:0]    itype,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [1:0]    word_idx,
  output logic          instr_done
);
  logic             beat;
  logic [IDX_W-1:0] beat_idx;
  logic             beat_final;

  ofb_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_ready(start_ready),
    .start_addr (start_addr),
    .burst_en   (burst_en),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_len    (bus_len),
    .bus_gnt    (bus_gnt),
    .bus_dvalid (bus_dvalid),
    .bus_last   (bus_last),
    .itype      (itype),
    .beat       (beat),
    .beat_idx   (beat_idx),
    .beat_final (beat_final)
  );

  ofb_word_out #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .beat_data (bus_rdata),
    .beat_idx  (beat_idx),
    .beat_final(beat_final),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_idx  (word_idx),
    .instr_done(instr_done)
  );
endmodule

// File: tb/tb_ofb_seq.sv
module tb_ofb_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [AW-1:0] start_addr = '0;
  logic          burst_en = 1'b0;
  logic          bus_req;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_len;
  logic          bus_gnt = 1'b0;
  logic          bus_dvalid = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_last = 1'b0;
  logic [1:0]    itype = 2'd0;
  logic          word_valid;
  logic [DW-1:0] word_data;
  logic [1:0]    word_idx;
  logic          instr_done;

  ofb_seq #(.AW(AW), .DW(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total_checks = 0;
  int bad_checks = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference for the word stream, compared every clock.
  int drv_idx = 0;
  int cur_total = 2;
  bit pend_v = 0;
  logic [DW-1:0] pend_d = '0;
  int pend_i = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(word_valid == pend_v, "R9", "word_valid", word_valid, pend_v);
      if (pend_v) begin
        check(word_data == pend_d, "R9", "word_data", word_data, pend_d);
        check(word_idx == pend_i[1:0], "R9", "word_idx", word_idx, pend_i);
        check(instr_done == (pend_i == cur_total - 1), "R10", "instr_done", instr_done,
              (pend_i == cur_total - 1));
      end else begin
        check(instr_done == 1'b0, "R10", "instr_done idle", instr_done, 0);
      end
      pend_v = bus_dvalid;
      pend_d = bus_rdata;
      pend_i = drv_idx;
    end
  end

  function automatic int words_of(int t);
    case (t)
      0: return 2;
      1, 2: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic run_fetch(logic [AW-1:0] addr, bit burst, int typ, bit flip);
    int lens[$];
    int off = 0;
    int left;
    logic [AW-1:0] a0;
    logic [1:0] l0;
    string tag;
    cur_total = words_of(typ);
    if (burst) begin
      lens.push_back(2);
      left = cur_total - 2;
      if (left > 0) lens.push_back(left >= 2 ? 2 : 1);
    end else begin
      for (int i = 0; i < cur_total; i++) lens.push_back(1);
    end
    @(posedge clk); #1;
    start_valid = 1; start_addr = addr; burst_en = burst;
    @(negedge clk);
    check(start_ready == 1'b1, "R1", "start_ready idle", start_ready, 1);
    @(posedge clk); #1;
    start_valid = 0;
    if (flip) burst_en = ~burst;
    @(negedge clk);
    check(start_ready == 1'b0, "R1", "start_ready busy", start_ready, 0);
    for (int k = 0; k < lens.size(); k++) begin
      int d = $urandom_range(0, 2);
      if (flip) tag = "R11";
      else if (!burst) tag = "R7";
      else if (k == 0) tag = "R2";
      else if (typ == 3) tag = "R6";
      else tag = "R5";
      while (!bus_req) @(negedge clk);
      check(bus_addr == addr + AW'(4 * off), tag, "bus_addr", bus_addr, addr + AW'(4 * off));
      check(bus_len == 2'(lens[k]), tag, "bus_len", bus_len, lens[k]);
      a0 = bus_addr; l0 = bus_len;
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        check(bus_req && bus_addr == a0 && bus_len == l0, "R3", "request held",
              {bus_req, bus_addr}, {1'b1, a0});
      end
      @(posedge clk); #1;
      bus_gnt = 1;
      @(posedge clk); #1;
      bus_gnt = 0;
      for (int b = 0; b < lens[k]; b++) begin
        if ($urandom_range(0, 2) == 0) begin
          itype = 2'($urandom);
          @(posedge clk); #1;
        end
        bus_dvalid = 1;
        bus_rdata = $urandom;
        bus_last = (b == lens[k] - 1);
        drv_idx = off + b;
        itype = (off + b == 0) ? 2'(typ) : 2'($urandom);
        @(posedge clk); #1;
        bus_dvalid = 0; bus_last = 0;
      end
      off += lens[k];
      @(negedge clk);
      check(bus_req == 1'b0, "R8", "request after last beat", bus_req, 0);
    end
    repeat (2) begin
      @(negedge clk);
      check(bus_req == 1'b0, "R4", "no extra access", bus_req, 0);
    end
    check(start_ready == 1'b1, "R1", "start_ready after fetch", start_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad_checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(start_ready == 1'b1, "R1", "reset start_ready", start_ready, 1);
    check(bus_req == 1'b0, "R8", "reset bus_req", bus_req, 0);
    check(word_valid == 1'b0, "R9", "reset word_valid", word_valid, 0);
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < 4; t++)
        run_fetch(32'h1000 + 32'(t * 64) + 32'(b * 1024), bit'(b), t, 0);
    run_fetch(32'h2000, 1, 3, 1);
    run_fetch(32'h2100, 0, 1, 1);
    run_fetch(32'h2200, 1, 2, 1);
    for (int r = 0; r < 20; r++)
      run_fetch({$urandom} & 32'hFFFF_FFFC, bit'($urandom_range(0, 1)),
                $urandom_range(0, 3), bit'($urandom_range(0, 1)));
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule